// File: doc/BRIEF.md
# Interrupt Aggregator for a Service Processor

This block collects up to 64 interrupt lines into latched pending bits and folds them into one request for a service processor. Line 0 carries the non-maskable channel and lines 1 to 15 take direct inputs. Lines 16 to 18 take banked peripheral inputs, and each higher line is a muxed line. A muxed line is the OR of a group of eight shared inputs out of 128, and each of those inputs has its own mux-enable bit.

The service processor programs the block through a word-addressed read/write port. A line reaches the request when it is pending, enabled and not masked, and when its response bit is clear. Software sets a response bit when it takes a source, and the bit holds that source off the request until software writes it back to zero. A read-only vector word gives a programmable base plus four times the index of the lowest pending, enabled, unmasked line. It gives the base alone when no such line exists. There is no priority arbitration and no fast-interrupt path.

Top module: `intc_aggregator`

## Requirements
- R1: After synchronous reset every register reads zero, the vector word reads zero and `svc_irq` is low.
- R2: A pending bit is set on each clock edge where its line is high, whatever the enable, mask and response bits hold, and it stays set after the line falls.
- R3: Writing a word at pending offset 0x10+4n clears each pending bit whose data bit is one and leaves the others alone. If the line is still high in the same cycle, the bit stays set.
- R4: Line 0 follows `nmi_in`. Line k for 1..15 follows `direct_in[k-1]`, and line k for 16..18 follows `banked_in[k-16]`.
- R5: Muxed line 19+g is high when any input `mux_in[8g+j]` (j from 0 to 7) is high and its mux-enable bit 8g+j is set. Mux-enable word n at 0xC0+4n holds the enables for inputs 32n to 32n+31, one per bit.
- R6: `svc_irq` is the OR over all lines of pending AND enable AND NOT mask AND NOT response. A set response bit blocks its line until the bit is written to zero.
- R7: A read at 0x00 returns the base plus 4 times the lowest index whose pending, enable and not-mask terms are all true, or the base when none is. Writes to 0x00 have no effect.
- R8: The base sits at 0x04, enable word n at 0x40+4n, mask word n at 0x50+4n and response word n at 0x60+4n, and every one of them reads back what was last written. Unmapped offsets read zero and ignore writes, and `bus_rdata` is zero while `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access select; read data is driven only while high |
| bus_wr | input | 1 | Write strobe, taken at the clock edge while `bus_sel` is high |
| bus_addr | input | 8 | Byte offset of the accessed word (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| nmi_in | input | 1 | Non-maskable channel source, line 0 |
| direct_in | input | 15 | Direct sources, lines 1 to 15 |
| banked_in | input | 3 | Banked peripheral sources, lines 16 to 18 |
| mux_in | input | 128 | Shared inputs feeding the muxed lines in groups of eight |
| svc_irq | output | 1 | Global request to the service processor |

## Verification
The bench builds the block with its default parameters: two 32-bit words per bank, 64 lines in all, and 128 mux inputs in sixteen groups of eight. Under these values the second pending, enable, mask and response words are in use. The last muxed group (line 34, driven from the top mux-enable word) can be reached, and so can the vector arithmetic for indices above 31. Directed sequences cover W1C against a held source, response blocking and the mux enables. A random phase of inputs and writes is then compared against a behavioural model on every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_W        = 32;
    localparam int DEF_WORDS    = 2;
    localparam int DEF_MUX_IN   = 128;
    localparam int DEF_GROUP    = 8;
    localparam int DIRECT_N     = 15;
    localparam int BANKED_N     = 3;
    localparam int MUX_FIRST    = 1 + DIRECT_N + BANKED_N;
    localparam int MAX_LINES    = 64;

    // word offsets (byte offset / 4) of each bank
    localparam logic [5:0] W_VEC   = 6'h00;
    localparam logic [5:0] W_BASE  = 6'h01;
    localparam logic [5:0] W_PEND  = 6'h04;
    localparam logic [5:0] W_EN    = 6'h10;
    localparam logic [5:0] W_MASK  = 6'h14;
    localparam logic [5:0] W_RESP  = 6'h18;
    localparam logic [5:0] W_MUXEN = 6'h30;

    typedef enum logic [2:0] {
        RK_NONE, RK_VEC, RK_BASE, RK_PEND, RK_EN, RK_MASK, RK_RESP, RK_MUXEN
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode(input logic [7:0] addr, input int nw, input int mw);
        reg_sel_t   s;
        logic [5:0] w;
        w = addr[7:2];
        s.kind = RK_NONE;
        s.idx  = '0;
        if (w == W_VEC) begin
            s.kind = RK_VEC;
        end else if (w == W_BASE) begin
            s.kind = RK_BASE;
        end else if (w >= W_PEND && int'(w) < int'(W_PEND) + nw) begin
            s.kind = RK_PEND;  s.idx = 4'(w - W_PEND);
        end else if (w >= W_EN && int'(w) < int'(W_EN) + nw) begin
            s.kind = RK_EN;    s.idx = 4'(w - W_EN);
        end else if (w >= W_MASK && int'(w) < int'(W_MASK) + nw) begin
            s.kind = RK_MASK;  s.idx = 4'(w - W_MASK);
        end else if (w >= W_RESP && int'(w) < int'(W_RESP) + nw) begin
            s.kind = RK_RESP;  s.idx = 4'(w - W_RESP);
        end else if (w >= W_MUXEN && int'(w) < int'(W_MUXEN) + mw) begin
            s.kind = RK_MUXEN; s.idx = 4'(w - W_MUXEN);
        end
        return s;
    endfunction

    // index of the lowest set bit, MAX_LINES when none is set
    function automatic logic [6:0] lowest_set(input logic [MAX_LINES-1:0] v);
        logic [6:0] r;
        r = 7'(MAX_LINES);
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (v[i]) r = 7'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_line_collect.sv
module intc_line_collect
    import intc_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter int MUX_INPUTS = 128,
    parameter int GROUP      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  nmi_in,
    input  logic [DIRECT_N-1:0]   direct_in,
    input  logic [BANKED_N-1:0]   banked_in,
    input  logic [MUX_INPUTS-1:0] mux_in,
    input  logic [MUX_INPUTS-1:0] mux_en,
    output logic [NUM_LINES-1:0]  lines
);
    localparam int MUX_LINES = MUX_INPUTS / GROUP;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        if (l == 0) begin : g_nmi
            assign lines[l] = nmi_in;
        end else if (l <= DIRECT_N) begin : g_direct
            assign lines[l] = direct_in[l-1];
        end else if (l < MUX_FIRST) begin : g_banked
            assign lines[l] = banked_in[l-DIRECT_N-1];
        end else if (l - MUX_FIRST < MUX_LINES) begin : g_mux
            logic [GROUP-1:0] grp_in, grp_en;
            assign grp_in   = mux_in[(l-MUX_FIRST)*GROUP +: GROUP];
            assign grp_en   = mux_en[(l-MUX_FIRST)*GROUP +: GROUP];
            assign lines[l] = |(grp_in & grp_en);
            // R5: a group with no enabled input never drives its line
            a_r5_group_gated: assert property (@(posedge clk) disable iff (rst)
                (grp_en == '0) |-> !lines[l]);
        end else begin : g_unused
            assign lines[l] = 1'b0;
        end
    end

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_WORDS  = 2,
    parameter int MUX_INPUTS = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [7:0]                   bus_addr,
    input  logic [REG_W-1:0]             bus_wdata,
    output logic [REG_W-1:0]             bus_rdata,
    input  logic [NUM_WORDS*REG_W-1:0]   lines,
    input  logic [REG_W-1:0]             vector,
    output logic [NUM_WORDS*REG_W-1:0]   pend,
    output logic [NUM_WORDS*REG_W-1:0]   en,
    output logic [NUM_WORDS*REG_W-1:0]   mask,
    output logic [NUM_WORDS*REG_W-1:0]   resp,
    output logic [REG_W-1:0]             base,
    output logic [MUX_INPUTS-1:0]        mux_en
);
    localparam int NUM_LINES = NUM_WORDS * REG_W;
    localparam int MUX_WORDS = MUX_INPUTS / REG_W;

    reg_sel_t             sel;
    logic                 wr_en;
    logic [NUM_LINES-1:0] clr;

    assign sel   = decode(bus_addr, NUM_WORDS, MUX_WORDS);
    assign wr_en = bus_sel && bus_wr;

    always_comb begin
        clr = '0;
        if (wr_en && sel.kind == RK_PEND) clr[int'(sel.idx)*REG_W +: REG_W] = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            en     <= '0;
            mask   <= '0;
            resp   <= '0;
            base   <= '0;
            mux_en <= '0;
        end else begin
            pend <= (pend & ~clr) | lines;
            if (wr_en) begin
                case (sel.kind)
                    RK_BASE:  base <= bus_wdata;
                    RK_EN:    en[int'(sel.idx)*REG_W +: REG_W]     <= bus_wdata;
                    RK_MASK:  mask[int'(sel.idx)*REG_W +: REG_W]   <= bus_wdata;
                    RK_RESP:  resp[int'(sel.idx)*REG_W +: REG_W]   <= bus_wdata;
                    RK_MUXEN: mux_en[int'(sel.idx)*REG_W +: REG_W] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (sel.kind)
                RK_VEC:   bus_rdata = vector;
                RK_BASE:  bus_rdata = base;
                RK_PEND:  bus_rdata = pend[int'(sel.idx)*REG_W +: REG_W];
                RK_EN:    bus_rdata = en[int'(sel.idx)*REG_W +: REG_W];
                RK_MASK:  bus_rdata = mask[int'(sel.idx)*REG_W +: REG_W];
                RK_RESP:  bus_rdata = resp[int'(sel.idx)*REG_W +: REG_W];
                RK_MUXEN: bus_rdata = mux_en[int'(sel.idx)*REG_W +: REG_W];
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2: every line high at an edge is latched at that edge
    a_r2_source_latched: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend & $past(lines)) == $past(lines)));

    // R3: pending bits only fall through a pending-word write
    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel.kind == RK_PEND) |=> (($past(pend) & ~pend) == '0));

endmodule

// File: rtl/intc_vector.sv
module intc_vector
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] en,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] resp,
    input  logic [REG_W-1:0]     base,
    output logic [REG_W-1:0]     vector,
    output logic                 svc_irq
);
    logic [NUM_LINES-1:0] active;
    logic [MAX_LINES-1:0] active_w;
    logic [6:0]           first;

    assign active   = pend & en & ~mask;
    assign active_w = MAX_LINES'(active);
    assign first    = lowest_set(active_w);
    assign svc_irq  = |(active & ~resp);
    assign vector   = (first == 7'(MAX_LINES)) ? base
                                              : base + {{(REG_W-9){1'b0}}, first, 2'b00};

    // R6: the request implies some pending, enabled, unblocked line
    a_r6_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        svc_irq |-> ((pend & en & ~resp) != '0));

    // R7: with nothing pending the vector equals the base
    a_r7_idle_vector: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (vector == base));

endmodule

// File: rtl/intc_aggregator.sv
module intc_aggregator
    import intc_pkg::*;
#(
    parameter int NUM_WORDS  = DEF_WORDS,
    parameter int MUX_INPUTS = DEF_MUX_IN,
    parameter int GROUP      = DEF_GROUP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  nmi_in,
    input  logic [14:0]           direct_in,
    input  logic [2:0]            banked_in,
    input  logic [MUX_INPUTS-1:0] mux_in,
    output logic                  svc_irq
);
    localparam int NUM_LINES = NUM_WORDS * REG_W;

    logic [NUM_LINES-1:0]  lines, pend, en, mask, resp;
    logic [REG_W-1:0]      base, vector;
    logic [MUX_INPUTS-1:0] mux_en;

    intc_line_collect #(
        .NUM_LINES (NUM_LINES),
        .MUX_INPUTS(MUX_INPUTS),
        .GROUP     (GROUP)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .nmi_in   (nmi_in),
        .direct_in(direct_in),
        .banked_in(banked_in),
        .mux_in   (mux_in),
        .mux_en   (mux_en),
        .lines    (lines)
    );

    intc_regs #(
        .NUM_WORDS (NUM_WORDS),
        .MUX_INPUTS(MUX_INPUTS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lines    (lines),
        .vector   (vector),
        .pend     (pend),
        .en       (en),
        .mask     (mask),
        .resp     (resp),
        .base     (base),
        .mux_en   (mux_en)
    );

    intc_vector #(
        .NUM_LINES(NUM_LINES)
    ) u_vec (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .en     (en),
        .mask   (mask),
        .resp   (resp),
        .base   (base),
        .vector (vector),
        .svc_irq(svc_irq)
    );

    // R1: the request is low in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !svc_irq);

endmodule

// File: tb/sim_intc_aggregator.sv
`timescale 1ns/1ps
module sim_intc_aggregator;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         nmi_in = 1'b0;
    logic [14:0]  direct_in = '0;
    logic [2:0]   banked_in = '0;
    logic [127:0] mux_in = '0;
    logic         svc_irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  model_on = 1'b0;

    always #4 clk = ~clk;

    intc_aggregator u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nmi_in(nmi_in), .direct_in(direct_in), .banked_in(banked_in),
        .mux_in(mux_in), .svc_irq(svc_irq)
    );

    // behavioural reference state
    logic [63:0]  m_pend, m_en, m_mask, m_resp;
    logic [31:0]  m_base;
    logic [127:0] m_mux;

    function automatic logic [63:0] m_lines();
        logic [63:0] r = '0;
        r[0] = nmi_in;
        for (int k = 1; k <= 15; k++) r[k] = direct_in[k-1];
        for (int k = 16; k <= 18; k++) r[k] = banked_in[k-16];
        for (int g = 0; g < 16; g++)
            for (int j = 0; j < 8; j++)
                if (mux_in[8*g+j] && m_mux[8*g+j]) r[19+g] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] m_vector();
        logic [63:0] a = m_pend & m_en & ~m_mask;
        for (int i = 0; i < 64; i++)
            if (a[i]) return m_base + 32'(4*i);
        return m_base;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int w = int'(a[7:2]);
        if (!bus_sel) return '0;
        case (w)
            0:  return m_vector();
            1:  return m_base;
            4:  return m_pend[31:0];
            5:  return m_pend[63:32];
            16: return m_en[31:0];
            17: return m_en[63:32];
            20: return m_mask[31:0];
            21: return m_mask[63:32];
            24: return m_resp[31:0];
            25: return m_resp[63:32];
            48: return m_mux[31:0];
            49: return m_mux[63:32];
            50: return m_mux[95:64];
            51: return m_mux[127:96];
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend = '0; m_en = '0; m_mask = '0; m_resp = '0; m_base = '0; m_mux = '0;
        end else begin
            logic [63:0] raw, clr;
            int w;
            raw = m_lines();
            clr = '0;
            w = int'(bus_addr[7:2]);
            if (bus_sel && bus_wr) begin
                if (w == 4) clr[31:0]  = bus_wdata;
                if (w == 5) clr[63:32] = bus_wdata;
            end
            m_pend = (m_pend & ~clr) | raw;
            if (bus_sel && bus_wr) begin
                case (w)
                    1:  m_base = bus_wdata;
                    16: m_en[31:0] = bus_wdata;
                    17: m_en[63:32] = bus_wdata;
                    20: m_mask[31:0] = bus_wdata;
                    21: m_mask[63:32] = bus_wdata;
                    24: m_resp[31:0] = bus_wdata;
                    25: m_resp[63:32] = bus_wdata;
                    48: m_mux[31:0] = bus_wdata;
                    49: m_mux[63:32] = bus_wdata;
                    50: m_mux[95:64] = bus_wdata;
                    51: m_mux[127:96] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && !rst && !done) begin
            logic exp_irq;
            logic [31:0] exp_rd;
            exp_irq = |(m_pend & m_en & ~m_mask & ~m_resp);
            exp_rd  = m_read(bus_addr);
            n_checks++;
            if (svc_irq !== exp_irq) begin
                n_fail++;
                $display("FAIL R6 model svc_irq actual=%0b expected=%0b", svc_irq, exp_irq);
            end
            n_checks++;
            if (bus_rdata !== exp_rd) begin
                n_fail++;
                $display("FAIL %s model read @%02h actual=%08h expected=%08h",
                         (bus_addr[7:2] == 0) ? "R7" : "R8", bus_addr, bus_rdata, exp_rd);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        check(bus_rdata === exp, tag, bus_rdata, exp);
        @(negedge clk); #1;
        bus_sel = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic irq_is(input logic exp, input string tag);
        @(negedge clk); #3;
        check(svc_irq === exp, tag, 32'(svc_irq), 32'(exp));
    endtask

    task automatic cycle();
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        model_on = 1'b1;

        // R1: reset state
        irq_is(1'b0, "R1 irq after reset");
        rd(8'h00, 32'h0, "R1 vector after reset");
        rd(8'h04, 32'h0, "R1 base after reset");
        rd(8'h44, 32'h0, "R1 enable1 after reset");
        rd(8'hCC, 32'h0, "R1 muxen3 after reset");

        // R2/R4: one-cycle pulse on the non-maskable channel latches while disabled
        cycle(); nmi_in = 1'b1;
        cycle(); nmi_in = 1'b0;
        rd(8'h10, 32'h1, "R2 line0 latched without enable");
        irq_is(1'b0, "R6 disabled line does not request");

        wr(8'h40, 32'h1);
        irq_is(1'b1, "R6 enabled pending line requests");
        rd(8'h00, 32'h0, "R7 vector line0 base0");
        wr(8'h04, 32'h1000);
        rd(8'h00, 32'h1000, "R7 vector follows base");
        wr(8'h00, 32'hFFFF);
        rd(8'h00, 32'h1000, "R7 vector write ignored");

        // R3/R4: direct line 5, then clear line 0
        cycle(); direct_in[4] = 1'b1;
        cycle(); direct_in[4] = 1'b0;
        wr(8'h10, 32'h1);
        rd(8'h10, 32'h20, "R3 w1c clears only line0");
        wr(8'h40, 32'h21);
        rd(8'h00, 32'h1014, "R7 vector lowest active line5");

        // R6/R7: mask and response
        wr(8'h50, 32'h20);
        irq_is(1'b0, "R6 masked line does not request");
        rd(8'h00, 32'h1000, "R7 masked line leaves base");
        wr(8'h50, 32'h0);
        wr(8'h60, 32'h20);
        irq_is(1'b0, "R6 response blocks request");
        rd(8'h60, 32'h20, "R8 response readback");
        wr(8'h60, 32'h0);
        irq_is(1'b1, "R6 response cleared restores request");

        // R4: banked line 17
        cycle(); banked_in[1] = 1'b1;
        cycle(); banked_in[1] = 1'b0;
        rd(8'h10, 32'h0002_0020, "R4 banked input lands on line17");

        // R5: muxed group 3 with its enable off, then on
        wr(8'h10, 32'hFFFF_FFFF);
        cycle(); mux_in[26] = 1'b1;
        cycle();
        rd(8'h10, 32'h0, "R5 disabled mux input ignored");
        wr(8'hC0, 32'h0400_0000);
        rd(8'h10, 32'h0040_0000, "R5 enabled mux input sets line22");
        mux_in[26] = 1'b0;
        wr(8'h10, 32'hFFFF_FFFF);

        // R5/R7: last group, high word
        wr(8'hCC, 32'h8000_0000);
        cycle(); mux_in[127] = 1'b1;
        cycle(); mux_in[127] = 1'b0;
        rd(8'h14, 32'h4, "R5 top mux input sets line34");
        wr(8'h44, 32'h4);
        wr(8'h40, 32'h0);
        rd(8'h00, 32'h1000 + 32'd136, "R7 vector for line34");
        irq_is(1'b1, "R6 request from high word");

        // R3: clear while source held
        wr(8'h14, 32'hFFFF_FFFF);
        direct_in[0] = 1'b1;
        wr(8'h10, 32'h2);
        rd(8'h10, 32'h2, "R3 held source survives w1c");
        direct_in[0] = 1'b0;
        wr(8'h10, 32'h2);
        rd(8'h10, 32'h0, "R3 w1c after source drops");

        // R8: unmapped offset and idle select
        wr(8'h08, 32'hDEAD_BEEF);
        rd(8'h08, 32'h0, "R8 unmapped reads zero");
        rd(8'h04, 32'h1000, "R8 unmapped write left base");
        @(negedge clk); #1; bus_addr = 8'h04; #2;
        check(bus_rdata === 32'h0, "R8 rdata zero without select", bus_rdata, 32'h0);
        bus_addr = 8'h00;

        // random phase compared against the model every cycle
        for (int it = 0; it < 600; it++) begin
            @(negedge clk); #1;
            nmi_in    = ($urandom % 8) == 0;
            direct_in = 15'($urandom & $urandom & $urandom);
            banked_in = 3'($urandom & $urandom);
            mux_in    = {$urandom & $urandom, $urandom & $urandom,
                         $urandom & $urandom, $urandom & $urandom};
            if (($urandom % 3) == 0) begin
                logic [7:0] addrs [14];
                addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h40, 8'h44, 8'h50,
                          8'h54, 8'h60, 8'h64, 8'hC0, 8'hC4, 8'hC8, 8'hCC};
                bus_sel   = 1'b1;
                bus_wr    = $urandom % 2;
                bus_addr  = addrs[$urandom % 14];
                bus_wdata = $urandom;
            end else begin
                bus_sel  = ($urandom % 2) == 0;
                bus_wr   = 1'b0;
                bus_addr = 8'h00;
            end
        end
        @(negedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule